// File: doc/BRIEF.md
# March-Test Memory Self-Test Engine

This block is a built-in self-test controller for a synchronous single-port SRAM with 32-bit words. A one-cycle start pulse launches two passes of a fixed six-element march over a parameterised word range. Each pass uses its own pair of complementary data backgrounds. The engine issues one memory operation per cycle on the address, write-data, write-enable and read-enable lines. It compares every returned read word against the expected background and counts mismatches in a saturating counter.

At the end of each pass the engine places a one-cycle status word on the result interface. The slot field tells which pass the word belongs to. After the second pass a done flag rises and stays high until the next start. Address scrambling, repair and failure logging are handled elsewhere.

Top module: `march_bist`

## Requirements
- R1: A start pulse while idle or done begins pass 1 in the next cycle. The done flag is low from that cycle on. A start pulse during a run has no effect on the sequence or its timing. The done flag rises in the cycle after the pass 2 result and holds until the next start.
- R2: Each pass issues exactly one operation per cycle (never a read and a write together), with 14 operations per word. The element order is: up W0; down R0,W1; up R1,W0,R0,W1; up R1,W0; up R0,W1,R1,W0; up R0. Here W0/W1 write background 0/1 and R0/R1 read and expect it.
- R3: The descending element starts at word END_WORD-1 and ends after word BASE_WORD has been handled. Every other element runs from BASE_WORD up to END_WORD-1.
- R4: Pass 1 uses backgrounds 0x00000000 / 0xFFFFFFFF and pass 2 uses 0x55555555 / 0xAAAAAAAA (background 0 / background 1).
- R5: Read data is compared one cycle after the read is issued. Each mismatch adds one to the error count, and the sequence never stops or changes length because of mismatches.
- R6: The error count is cleared between passes, so the pass 2 result depends only on pass 2 reads.
- R7: A pass result is valid for one cycle, 14*N+1 cycles after the pass starts (N = END_WORD-BASE_WORD). The code is 0x0000BEAD when the count is zero and 0x00000BAD otherwise. The slot is 0 for pass 1 and 1 for pass 2.
- R8: The error count saturates at its maximum, so any number of mismatches still reports 0x00000BAD.
- R9: BASE_WORD, END_WORD, ADDR_W and the counter width ERR_W are parameters. Pass 2 starts in the cycle after the pass 1 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle test start pulse |
| mem_addr_o | output | ADDR_W | SRAM word address |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_we_o | output | 1 | SRAM write enable |
| mem_re_o | output | 1 | SRAM read enable, data returned next cycle |
| mem_rdata_i | input | 32 | SRAM read data |
| res_valid_o | output | 1 | Pass result strobe |
| res_slot_o | output | 1 | Result slot, 0 = pass 1, 1 = pass 2 |
| res_code_o | output | 32 | Pass status code |
| done_o | output | 1 | Both passes finished |

## Verification
The hardest conditions to reach are a pass whose only faults fall in the other pass, and an error total that is an exact multiple of the counter range. Either one would hide a missing clear or a wrapping counter. The bench runs a behavioural memory with stuck-at and coupling faults that can be switched on for one pass only. It uses a 3-bit counter and stuck-at-zero words that cause exactly 24 pass 1 mismatches. A separate software run of the march on the same fault model gives the expected codes.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] CODE_PASS = 32'h0000_BEAD;
  localparam logic [DATA_W-1:0] CODE_FAIL = 32'h0000_0BAD;

  typedef enum logic [2:0] {PH_IDLE, PH_RUN, PH_DRAIN, PH_REPORT, PH_DONE} phase_e;

  typedef struct packed {
    logic wr;
    logic bg;
  } op_t;

  // operation at (element, step) of the march
  function automatic op_t op_at(input logic [2:0] elem, input logic [1:0] step);
    op_t o;
    o = '{wr: 1'b0, bg: 1'b0};
    case (elem)
      3'd0: o = '{wr: 1'b1, bg: 1'b0};
      3'd1: o = '{wr: step[0], bg: step[0]};
      3'd2: o = '{wr: step[0], bg: (step == 2'd0) || (step == 2'd3)};
      3'd3: o = '{wr: step[0], bg: ~step[0]};
      3'd4: o = '{wr: step[0], bg: (step == 2'd1) || (step == 2'd2)};
      default: o = '{wr: 1'b0, bg: 1'b0};
    endcase
    return o;
  endfunction

  function automatic logic [1:0] last_step(input logic [2:0] elem);
    case (elem)
      3'd1, 3'd3: return 2'd1;
      3'd2, 3'd4: return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bg_word(input logic pass, input logic sel);
    if (!pass) return sel ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    return sel ? {(DATA_W/2){2'b10}} : {(DATA_W/2){2'b01}};
  endfunction
endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_WORD = 0,
  parameter int END_WORD  = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              issue_o,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pass_o,
  output logic              report_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(END_WORD - 1);

  phase_e            phase_q;
  logic              pass_q;
  logic [2:0]        elem_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] addr_q;
  logic              desc, at_end;

  assign desc   = (elem_q == 3'd1);
  assign at_end = desc ? (addr_q == BASE_A) : (addr_q == LAST_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pass_q  <= 1'b0;
      elem_q  <= '0;
      step_q  <= '0;
      addr_q  <= BASE_A;
    end else begin
      case (phase_q)
        PH_IDLE, PH_DONE: if (start_i) begin
          phase_q <= PH_RUN;
          pass_q  <= 1'b0;
          elem_q  <= '0;
          step_q  <= '0;
          addr_q  <= BASE_A;
        end
        PH_RUN: begin
          if (step_q != last_step(elem_q)) begin
            step_q <= step_q + 2'd1;
          end else begin
            step_q <= '0;
            if (!at_end) begin
              addr_q <= desc ? addr_q - 1'b1 : addr_q + 1'b1;
            end else if (elem_q == 3'd5) begin
              phase_q <= PH_DRAIN;
            end else begin
              elem_q <= elem_q + 3'd1;
              addr_q <= (elem_q == 3'd0) ? LAST_A : BASE_A;
            end
          end
        end
        PH_DRAIN: phase_q <= PH_REPORT;
        PH_REPORT: begin
          if (!pass_q) begin
            phase_q <= PH_RUN;
            pass_q  <= 1'b1;
            elem_q  <= '0;
            addr_q  <= BASE_A;
          end else begin
            phase_q <= PH_DONE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign issue_o  = (phase_q == PH_RUN);
  assign op_o     = op_at(elem_q, step_q);
  assign addr_o   = addr_q;
  assign pass_o   = pass_q;
  assign report_o = (phase_q == PH_REPORT);
  assign done_o   = (phase_q == PH_DONE);

  assert_done_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_desc_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && elem_q == 3'd1) |=> (elem_q == 3'd1 || $past(addr_q) == BASE_A));
  assert_desc_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && elem_q == 3'd0) |=> (elem_q == 3'd0 || addr_q == LAST_A));
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              chk_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              clean_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic              chk_q;
  logic [DATA_W-1:0] exp_q;
  logic [ERR_W-1:0]  cnt_q;
  logic              miss;

  // expected word travels with the read, one cycle of SRAM latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
      exp_q <= '0;
    end else begin
      chk_q <= chk_i;
      exp_q <= exp_i;
    end
  end

  assign miss = chk_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (miss && cnt_q != ERR_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign clean_o = (cnt_q == '0);

  assert_count_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss && !clear_i) |=> (cnt_q != '0));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == ERR_MAX && !clear_i) |=> (cnt_q == ERR_MAX));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> clean_o);
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_WORD = 0,
  parameter int END_WORD  = 65536,
  parameter int ERR_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              res_valid_o,
  output logic              res_slot_o,
  output logic [31:0]       res_code_o,
  output logic              done_o
);
  logic              issue, pass, report, clean;
  op_t               op;
  logic [DATA_W-1:0] bg;

  march_seq #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD), .END_WORD(END_WORD)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .issue_o(issue), .op_o(op), .addr_o(mem_addr_o),
    .pass_o(pass), .report_o(report), .done_o(done_o)
  );

  assign bg = bg_word(pass, op.bg);

  march_cmp #(.ERR_W(ERR_W)) u_cmp (
    .clk_i, .rst_ni,
    .clear_i(report), .chk_i(mem_re_o), .exp_i(bg),
    .rdata_i(mem_rdata_i), .clean_o(clean)
  );

  assign mem_we_o    = issue && op.wr;
  assign mem_re_o    = issue && !op.wr;
  assign mem_wdata_o = bg;
  assign res_valid_o = report;
  assign res_slot_o  = pass;
  assign res_code_o  = clean ? CODE_PASS : CODE_FAIL;

  assert_one_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  assert_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  assert_quiet_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(mem_we_o || mem_re_o));
endmodule

// File: tb/sim_march_bist.sv
`timescale 1ns/1ps
module sim_march_bist;
  localparam int AW = 4, BASE = 2, ENDW = 12, EW = 3;
  localparam int N = ENDW - BASE;
  localparam int P = 14 * N + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata, code;
  logic we, re, rvalid, rslot, done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  march_bist #(.ADDR_W(AW), .BASE_WORD(BASE), .END_WORD(ENDW), .ERR_W(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
    .mem_rdata_i(rdata), .res_valid_o(rvalid), .res_slot_o(rslot),
    .res_code_o(code), .done_o(done)
  );

  // behavioural SRAM with faults
  logic [31:0] mem [16], rmem [16], sa0 [16], sa1 [16];
  logic fault_on = 1'b0, wipe = 1'b0, cf_en = 1'b0;
  int cf_aggr = 0, cf_vict = 0, cf_bit = 0;

  function automatic logic [31:0] faulty(input logic [31:0] v, input int a, input logic fon);
    return fon ? ((v & ~sa0[a]) | sa1[a]) : v;
  endfunction

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (we) begin
        mem[addr] <= wdata;
        if (fault_on && cf_en && int'(addr) == cf_aggr && !mem[addr][cf_bit] && wdata[cf_bit])
          mem[cf_vict][cf_bit] <= ~mem[cf_vict][cf_bit];
      end
      if (re) rdata <= faulty(mem[addr], int'(addr), fault_on);
    end
  end

  function automatic logic [31:0] bgv(input int p, input int sel);
    if (p == 0) return sel ? 32'hFFFF_FFFF : 32'h0;
    return sel ? 32'hAAAA_AAAA : 32'h5555_5555;
  endfunction

  // 0=R0 1=R1 2=W0 3=W1
  function automatic int opc(input int e, input int s);
    case (e)
      0: return 2;
      1: return s == 0 ? 0 : 3;
      2: case (s) 0: return 1; 1: return 2; 2: return 0; default: return 3; endcase
      3: return s == 0 ? 1 : 2;
      4: case (s) 0: return 0; 1: return 3; 2: return 1; default: return 2; endcase
      default: return 0;
    endcase
  endfunction

  function automatic int nops(input int e);
    case (e) 0, 5: return 1; 1, 3: return 2; default: return 4; endcase
  endfunction

  task automatic ref_pass(input int p, input logic fon, output int errs);
    errs = 0;
    for (int e = 0; e < 6; e++)
      for (int k = 0; k < N; k++) begin
        int a = (e == 1) ? ENDW - 1 - k : BASE + k;
        for (int s = 0; s < nops(e); s++) begin
          int c = opc(e, s);
          if (c < 2) begin
            if (faulty(rmem[a], a, fon) != bgv(p, c)) errs++;
          end else begin
            logic [31:0] w = bgv(p, c - 2);
            if (fon && cf_en && a == cf_aggr && !rmem[a][cf_bit] && w[cf_bit])
              rmem[cf_vict][cf_bit] = ~rmem[cf_vict][cf_bit];
            rmem[a] = w;
          end
        end
      end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < 16; i++) begin sa0[i] = '0; sa1[i] = '0; end
    cf_en = 1'b0;
  endtask

  task automatic run(input logic f1, input logic f2, input bit detail);
    int e1, e2, strobes;
    logic [31:0] x1, x2;
    for (int i = 0; i < 16; i++) rmem[i] = '0;
    ref_pass(0, f1, e1);
    ref_pass(1, f2, e2);
    x1 = e1 != 0 ? 32'h0BAD : 32'hBEAD;
    x2 = e2 != 0 ? 32'h0BAD : 32'hBEAD;
    @(negedge clk) wipe = 1'b1;
    @(negedge clk) begin wipe = 1'b0; fault_on = f1; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    strobes = 0;
    chk(!done, "R1", "done clears on start", {31'b0, done}, 32'd0);
    for (int c = 0; c <= 2 * P; c++) begin
      if (rvalid) strobes++;
      if (detail) begin
        if (c == 0) chk(we && addr == BASE && wdata == 0, "R2", "first op W0 at base", {28'b0, addr}, BASE);
        if (c == N) chk(re && addr == ENDW - 1, "R3", "descending start", {28'b0, addr}, ENDW - 1);
        if (c == N + 1) chk(we && wdata == 32'hFFFF_FFFF, "R4", "pass1 bg1", wdata, 32'hFFFF_FFFF);
        if (c == 3 * N - 1) chk(we && addr == BASE, "R3", "descending end at base", {28'b0, addr}, BASE);
        if (c == 3 * N) chk(re && addr == BASE, "R2", "third element from base", {28'b0, addr}, BASE);
        if (c == P) chk(we && addr == BASE && wdata == 32'h5555_5555, "R4", "pass2 bg0", wdata, 32'h5555_5555);
        if (c == P + N + 1) chk(we && wdata == 32'hAAAA_AAAA, "R4", "pass2 bg1", wdata, 32'hAAAA_AAAA);
        if (c == 50) start = 1'b1;
        if (c == 51) start = 1'b0;
      end
      if (c == P - 1) begin
        chk(rvalid && !rslot, "R7", "slot0 strobe", {31'b0, rslot}, 32'd0);
        chk(code == x1, "R7", "pass1 code", code, x1);
        fault_on = f2;
      end
      if (c == 2 * P - 1) begin
        chk(rvalid && rslot, "R9", "slot1 strobe", {31'b0, rslot}, 32'd1);
        chk(code == x2, "R6", "pass2 code", code, x2);
        chk(!done, "R1", "done low before end", {31'b0, done}, 32'd0);
      end
      if (c == 2 * P) chk(done, "R1", "done after pass2", {31'b0, done}, 32'd1);
      @(negedge clk);
    end
    chk(strobes == 2, "R5", "result strobe count", strobes, 2);
    repeat (5) @(negedge clk);
    chk(done && !we && !re, "R1", "done holds", {31'b0, done}, 32'd1);
    fault_on = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    chk(!done && !rvalid && !we && !re, "R1", "reset state", {28'b0, done, rvalid, we, re}, 32'd0);
    rst_n = 1'b1;
    // R2 R3 R4: fault-free, start pulse mid-run ignored
    run(1'b0, 1'b0, 1'b1);
    // R5: stuck-at-1 bit 5 of word 3
    clear_faults(); sa1[3] = 32'h20; run(1'b1, 1'b1, 1'b0);
    // R5: stuck-at-0 bit 0 at the base word
    clear_faults(); sa0[BASE] = 32'h1; run(1'b1, 1'b1, 1'b0);
    // R5: coupling, aggressor below victim
    clear_faults(); cf_en = 1'b1; cf_aggr = 4; cf_vict = 7; cf_bit = 3; run(1'b1, 1'b1, 1'b0);
    // R5: coupling, aggressor above victim
    clear_faults(); cf_en = 1'b1; cf_aggr = 9; cf_vict = 2; cf_bit = 30; run(1'b1, 1'b1, 1'b0);
    // R6: fault in pass 1 only, last word
    clear_faults(); sa1[ENDW-1] = 32'hFFFF_FFFF; run(1'b1, 1'b0, 1'b0);
    // R8: eight stuck-zero words give 24 pass 1 errors, a multiple of 2**EW
    clear_faults();
    for (int i = BASE; i < BASE + 8; i++) sa0[i] = 32'hFFFF_FFFF;
    run(1'b1, 1'b0, 1'b0);
    // R9: back-to-back run after done, clean
    clear_faults(); run(1'b0, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule